// File: doc/BRIEF.md
# TLB invalidation request controller

This block lets software ask the address-translation caches to drop stale entries after page tables change. Software writes a 40-bit page directory base into a low word and a high byte, then writes a control word. The control word chooses the invalidation scope, whether the per-cluster L2 TLBs are included, and how far completion acknowledgments must reach. It also carries a trigger bit. Hardware clears the trigger bit when the flush is finished.

Once triggered, the block sends a single-cycle request to the hub TLB. Unless the hub-only flag is set, it sends the same request to every cluster L2 TLB. Each target answers with a single-cycle done pulse, and the block holds each pulse until the flush ends. Depending on the acknowledgment mode, the block clears the trigger right after issue, after every targeted local TLB has answered, or after the local answers plus a remote acknowledgment. The `busy` output follows the trigger bit. While a flush is running, all register writes are ignored.

Top module: `tlb_inval_ctrl`

## Requirements
- R1: Reset clears the base words, the control fields, the trigger and all pending acknowledgments. After reset, `busy` is 0, no request is valid, and every register reads 0.
- R2: Word 0 (`wr_addr`=0) holds base address bits [39:8] as a full 32-bit word. Word 1 keeps only `wr_data[7:0]`, which is base bits [47:40]; the upper bits of word 1 read as 0. With a request, `req_base` carries {word1[7:0], word0}.
- R3: The control word sits at word 2 with these bit positions: bit 0 invalidates all virtual addresses, bit 1 selects all bases, bit 2 restricts the flush to the hub, bits [8:7] hold the ack mode and bit 31 is the trigger. Writing it with bit 31 set starts a flush. Bit 31 then reads 1 and `busy` is 1 until the flush completes.
- R4: In the cycle after the triggering write, `hub_req_vld` pulses for exactly one cycle. Every bit of `clu_req_vld` pulses in that same cycle unless bit 2 is set; with bit 2 set, `clu_req_vld` stays 0.
- R5: With bit 1 set, `req_base` is 0 and `req_all_base` is 1, whatever the base words hold. `req_all_va` reflects bit 0.
- R6: Ack modes 0 and 3 clear the trigger on the clock edge that ends the request cycle, so `busy` lasts exactly one cycle.
- R7: Ack mode 2 clears the trigger on the edge where the last targeted local TLB's done pulse is seen. Done pulses may arrive in any order and are held until completion.
- R8: Ack mode 1 also waits for `remote_ack`. A remote acknowledgment that arrives before the local ones is held.
- R9: While `busy` is 1, writes to any register are ignored. This includes a second triggering write.
- R10: A control write with bit 31 clear stores the fields without starting a flush or issuing any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word select (0 base low, 1 base high, 2 control) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word select |
| rd_data | output | 32 | Combinational read data |
| busy | output | 1 | Flush in progress (mirrors trigger) |
| hub_req_vld | output | 1 | Invalidate request to hub TLB |
| clu_req_vld | output | NCLU | Invalidate request to each cluster L2 TLB |
| req_base | output | 40 | Base address bits [47:8] for the request |
| req_all_va | output | 1 | Invalidate all virtual addresses of the base |
| req_all_base | output | 1 | Invalidate entries of every base |
| hub_done | input | 1 | Hub TLB completion pulse |
| clu_done | input | NCLU | Cluster TLB completion pulses |
| remote_ack | input | 1 | Remote consumers' completion pulse |

## Verification
Suppose the held-acknowledgment state is wrong, for example a target bit left set or one that is never recorded. Then `busy` and the trigger bit fall one or more cycles away from the completing pulse, and the edge-exact checks after each done or remote pulse catch that. A wrong target mask shows up in `clu_req_vld` during the request cycle itself. A write that leaks through while busy shows up either at the next readback of the base or control word, or as a changing `req_base` while a flush is in flight.

// File: rtl/tlb_inval_ctrl.sv
module tlb_inval_ctrl #(
  parameter int NCLU = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic             busy,
  output logic             hub_req_vld,
  output logic [NCLU-1:0]  clu_req_vld,
  output logic [39:0]      req_base,
  output logic             req_all_va,
  output logic             req_all_base,
  input  logic             hub_done,
  input  logic [NCLU-1:0]  clu_done,
  input  logic             remote_ack
);
  localparam int NT = NCLU + 1;

  logic [31:0]   base_lo;
  logic [7:0]    base_hi;
  logic          f_allva, f_allbase, f_hub;
  logic [1:0]    f_ack;
  logic          trig, issue, rem_seen;
  logic [NT-1:0] acked;

  logic          accept;
  logic [NT-1:0] tgt, got;
  logic          local_ok, rem_ok, need_local, need_remote, finish;

  assign accept      = wr_en && !trig;
  assign tgt         = {{NCLU{~f_hub}}, 1'b1};
  assign got         = acked | {clu_done, hub_done};
  assign local_ok    = &(got | ~tgt);
  assign rem_ok      = rem_seen | remote_ack;
  assign need_remote = (f_ack == 2'd1);
  assign need_local  = (f_ack == 2'd1) || (f_ack == 2'd2);
  assign finish      = trig && (!need_local || (local_ok && (!need_remote || rem_ok)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo   <= '0;
      base_hi   <= '0;
      f_allva   <= 1'b0;
      f_allbase <= 1'b0;
      f_hub     <= 1'b0;
      f_ack     <= '0;
      trig      <= 1'b0;
      issue     <= 1'b0;
      rem_seen  <= 1'b0;
      acked     <= '0;
    end else begin
      issue <= 1'b0;
      if (accept) begin
        case (wr_addr)
          2'd0: base_lo <= wr_data;
          2'd1: base_hi <= wr_data[7:0];
          2'd2: begin
            f_allva   <= wr_data[0];
            f_allbase <= wr_data[1];
            f_hub     <= wr_data[2];
            f_ack     <= wr_data[8:7];
            if (wr_data[31]) begin
              trig     <= 1'b1;
              issue    <= 1'b1;
              acked    <= '0;
              rem_seen <= 1'b0;
            end
          end
          default: ;
        endcase
      end else if (trig) begin
        acked    <= got;
        rem_seen <= rem_ok;
        if (finish) trig <= 1'b0;
      end
    end
  end

  assign busy         = trig;
  assign hub_req_vld  = issue;
  assign clu_req_vld  = {NCLU{issue & ~f_hub}};
  assign req_base     = f_allbase ? 40'd0 : {base_hi, base_lo};
  assign req_all_va   = f_allva;
  assign req_all_base = f_allbase;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = base_lo;
      2'd1:    rd_data = {24'd0, base_hi};
      2'd2:    rd_data = {trig, 22'd0, f_ack, 4'd0, f_hub, f_allbase, f_allva};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tlb_inval_ctrl_sva.sv
module tlb_inval_ctrl_sva #(
  parameter int NCLU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            hub_req_vld,
  input logic [NCLU-1:0] clu_req_vld,
  input logic [39:0]     req_base,
  input logic            req_all_base
);
  p_pulse_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hub_req_vld |=> !hub_req_vld);

  p_start_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> hub_req_vld);

  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hub_req_vld |-> busy);

  p_clu_with_hub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clu_req_vld != '0) |-> hub_req_vld);

  p_clu_all_or_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clu_req_vld == '0) || (&clu_req_vld));

  p_allbase_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_req_vld && req_all_base) |-> (req_base == 40'd0));

  p_base_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(req_base));
endmodule

bind tlb_inval_ctrl tlb_inval_ctrl_sva #(.NCLU(NCLU)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .hub_req_vld(hub_req_vld),
  .clu_req_vld(clu_req_vld), .req_base(req_base), .req_all_base(req_all_base)
);

// File: tb/tb_tlb_inval_ctrl.sv
`timescale 1ns/1ps
module tb_tlb_inval_ctrl;
  localparam int NCLU = 4;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            wr_en = 0;
  logic [1:0]      wr_addr = 0;
  logic [31:0]     wr_data = 0;
  logic [1:0]      rd_addr = 0;
  logic [31:0]     rd_data;
  logic            busy, hub_req_vld, req_all_va, req_all_base;
  logic [NCLU-1:0] clu_req_vld;
  logic [39:0]     req_base;
  logic            hub_done = 0, remote_ack = 0;
  logic [NCLU-1:0] clu_done = 0;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  tlb_inval_ctrl #(.NCLU(NCLU)) dut (.*);

  // row: {all_va, all_base, hub_only, ack[1:0], exp_clusters, exp_wait[1:0]}
  // exp_wait: 0 none, 1 local only, 2 local plus remote
  localparam logic [7:0] TBL [6] = '{
    8'b1_0_0_00_1_00,
    8'b0_0_1_10_0_01,
    8'b1_0_0_10_1_01,
    8'b0_1_0_01_1_10,
    8'b1_0_1_01_0_10,
    8'b0_1_1_11_0_00
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic pulse_hub();  hub_done = 1;   @(negedge clk); hub_done = 0;   endtask
  task automatic pulse_clu();  clu_done = '1;  @(negedge clk); clu_done = '0;  endtask
  task automatic pulse_rem();  remote_ack = 1; @(negedge clk); remote_ack = 0; endtask

  function automatic logic [31:0] ctrl(input logic t, input logic [1:0] ack,
                                       input logic hub, input logic ab, input logic av);
    return {t, 22'd0, ack, 4'd0, hub, ab, av};
  endfunction

  initial begin
    #(4.0 * 200000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(busy, 0, "R1 busy");
    chk(hub_req_vld, 0, "R1 hub_req_vld");
    chk(clu_req_vld, 0, "R1 clu_req_vld");
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); chk(d, 0, "R1 register reads zero");
    end

    // Table walk
    for (int i = 0; i < 6; i++) begin
      logic av, ab, hb, cl;
      logic [1:0] ack, wt;
      logic [31:0] lo;
      logic [7:0] hi;
      {av, ab, hb, ack, cl, wt} = TBL[i];
      lo = 32'hA500_0000 + i;
      hi = 8'h30 + 8'(i);
      wr(2'd0, lo);
      wr(2'd1, {24'hFFFFFF, hi});
      wr(2'd2, ctrl(1'b1, ack, hb, ab, av));
      chk(busy, 1, "R3 busy after trigger");
      rd(2'd2, d); chk(d[31], 1, "R3 trigger reads one");
      chk(hub_req_vld, 1, "R4 hub request");
      chk(clu_req_vld, cl ? {NCLU{1'b1}} : '0, "R4 cluster requests");
      chk(req_base, ab ? 40'd0 : {hi, lo}, "R2 R5 request base");
      chk(req_all_base, ab, "R5 all-base flag");
      chk(req_all_va, av, "R5 all-va flag");
      @(negedge clk);
      chk(hub_req_vld, 0, "R4 hub request single cycle");
      if (wt == 2'd0) begin
        chk(busy, 0, "R6 trigger cleared after issue");
      end else begin
        chk(busy, 1, "R7 busy awaiting acks");
        pulse_hub();
        if (cl) begin
          chk(busy, 1, "R7 waits for clusters");
          pulse_clu();
        end
        if (wt == 2'd2) begin
          chk(busy, 1, "R8 waits for remote");
          pulse_rem();
        end
        chk(busy, 0, "R7 R8 complete");
      end
      rd(2'd2, d); chk(d[31], 0, "R3 trigger cleared");
    end

    // R2 high word keeps only 8 bits
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0000_01FF);
    rd(2'd0, d); chk(d, 32'hFFFF_FFFF, "R2 low word");
    rd(2'd1, d); chk(d, 32'h0000_00FF, "R2 high word");

    // R10 control write without trigger
    wr(2'd2, ctrl(1'b0, 2'd3, 1'b1, 1'b1, 1'b1));
    chk(busy, 0, "R10 no flush");
    chk(hub_req_vld, 0, "R10 no request");
    rd(2'd2, d); chk(d, 32'h0000_0187, "R10 fields stored");
    @(negedge clk);
    chk(hub_req_vld, 0, "R10 no request later");

    // R9 writes ignored while busy
    wr(2'd0, 32'h1234_5678);
    wr(2'd2, ctrl(1'b1, 2'd2, 1'b0, 1'b0, 1'b0));
    wr(2'd0, 32'hDEAD_BEEF);
    wr(2'd2, ctrl(1'b1, 2'd0, 1'b1, 1'b1, 1'b1));
    rd(2'd0, d); chk(d, 32'h1234_5678, "R9 base write ignored");
    rd(2'd2, d); chk(d, 32'h8000_0100, "R9 control write ignored");
    chk(req_base[31:0], 32'h1234_5678, "R9 request base unchanged");
    pulse_clu();
    chk(busy, 1, "R7 hub still pending");
    pulse_hub();
    chk(busy, 0, "R7 any order completes");

    // R8 early remote held
    wr(2'd2, ctrl(1'b1, 2'd1, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    pulse_rem();
    chk(busy, 1, "R8 remote alone not enough");
    hub_done = 1; clu_done = '1; @(negedge clk); hub_done = 0; clu_done = '0;
    chk(busy, 0, "R8 held remote completes");

    // R1 reset mid-flush
    wr(2'd2, ctrl(1'b1, 2'd2, 1'b0, 1'b0, 1'b0));
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk(busy, 0, "R1 reset clears busy");
    rd(2'd0, d); chk(d, 0, "R1 reset clears base");
    rd(2'd2, d); chk(d, 0, "R1 reset clears control");

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule